// File: doc/BRIEF.md
# Programmable Sum-of-Products Plane

This block is the configurable AND-OR plane of a small programmable logic device. Every dedicated input and every feedback signal from the output stage is offered to each product term in both true and inverted form. A configuration row per product term selects, for each literal, whether the term uses the true form, the inverted form, or ignores that literal. Each output owns eight summing terms, which are ORed into its sum line, and one further term that drives its enable line on its own.

The configuration is held in registers and written one row per clock through an address/data load port. Between writes it stays fixed, and the plane evaluates combinationally from the current inputs and feedback. After reset every row holds the erased pattern, in which each literal is tied in both forms, so every term and every output is 0 until rows are programmed. Reset is asserted asynchronously and released to the plane two clock edges after the reset input rises.

Top module: `sop_plane`

## Requirements
- R1: Literal j uses bits [2j+1:2j] of a row: bit 2j+1 set requires literal j to be 1, bit 2j set requires literal j to be 0; a term is the AND of all requirements its row sets.
- R2: While reset is applied and after it, with no row written, every row holds all ones and every sum and enable output is 0 for any inputs.
- R3: A write with cfg_we high and cfg_addr below the row count replaces exactly the addressed row at the clock edge, and the outputs reflect the new row from that edge on.
- R4: Row index = output*9 + slot; slots 0 to 7 are ORed into sum_o[output], slot 8 drives only oe_o[output].
- R5: A row whose fields are all 2'b00 evaluates to 1 whatever the inputs.
- R6: A field holding 2'b11 forces its term to 0 whatever the inputs.
- R7: A write to an address at or above the row count (90 by default) changes no row and no output.
- R8: Writes at the first two rising clock edges after the reset input rises are ignored; the third edge accepts a write.
- R9: With cfg_we low, rows hold their values and the outputs follow input changes without a clock edge.
- R10: Literals 0 to N_IN-1 are in_i bits, literals N_IN upward are fb_i bits, and both are used alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_i | input | N_IN (12) | Dedicated inputs, literals 0..N_IN-1 |
| fb_i | input | N_FB (10) | Feedback inputs, literals N_IN.. |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | $clog2(ROWS) (7) | Row index to write |
| cfg_data | input | 2*(N_IN+N_FB) (44) | Row contents, two bits per literal |
| sum_o | output | N_OUT (10) | OR of the eight summing terms per output |
| oe_o | output | N_OUT (10) | Enable term per output |

## Verification
Sum and enable outputs follow in_i and fb_i in the same cycle with no register on the way, so the bench changes inputs on a falling edge and checks a nanosecond later. A row write is captured at the next rising edge and is visible at once, so the bench drives the write on a falling edge and checks at the following falling edge. Reset release takes two rising edges before writes count, so the bench holds a write across the first three edges and checks after each of them that only the third one took effect.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // Per-literal link codes {use_true, use_comp}
  typedef enum logic [1:0] {
    LINK_NONE   = 2'b00,
    LINK_COMP   = 2'b01,
    LINK_TRUE   = 2'b10,
    LINK_ERASED = 2'b11
  } link_e;

  localparam int USE_TRUE_BIT = 1;
  localparam int USE_COMP_BIT = 0;
  localparam int SUM_SLOTS    = 8;
endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign core_rst_n = stage2_q;
endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int ROWS  = 90,
  parameter int ROW_W = 44,
  parameter int AW    = 7
) (
  input  logic                        clk,
  input  logic                        core_rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [ROW_W-1:0]            wr_data,
  output logic [ROWS-1:0][ROW_W-1:0]  rows_q
);
  logic                       addr_ok;
  logic                       upd_en;
  logic [ROWS-1:0][ROW_W-1:0] rows_d;

  assign addr_ok = (int'(wr_addr) < ROWS);
  assign upd_en  = wr_en && addr_ok;

  always_comb begin
    rows_d = rows_q;
    for (int r = 0; r < ROWS; r++) begin
      if (int'(wr_addr) == r) rows_d[r] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rows_q <= '1;
    end else if (upd_en) begin
      rows_q <= rows_d;
    end
  end
endmodule

// File: rtl/sop_term.sv
module sop_term #(
  parameter int LITS = 22
) (
  input  logic [LITS-1:0]   lits,
  input  logic [2*LITS-1:0] row,
  output logic              term
);
  import sop_pkg::*;

  always_comb begin
    term = 1'b1;
    for (int j = 0; j < LITS; j++) begin
      if (row[2*j+USE_TRUE_BIT] && !lits[j]) term = 1'b0;
      if (row[2*j+USE_COMP_BIT] &&  lits[j]) term = 1'b0;
    end
  end
endmodule

// File: rtl/sop_plane.sv
module sop_plane #(
  parameter int N_IN  = 12,
  parameter int N_FB  = 10,
  parameter int N_OUT = 10,
  localparam int LITS  = N_IN + N_FB,
  localparam int ROW_W = 2 * LITS,
  localparam int TPO   = sop_pkg::SUM_SLOTS + 1,
  localparam int ROWS  = N_OUT * TPO,
  localparam int AW    = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_FB-1:0]  fb_i,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [ROW_W-1:0] cfg_data,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_o
);
  import sop_pkg::*;

  logic                       core_rst_n;
  logic [ROWS-1:0][ROW_W-1:0] row_q;
  logic [LITS-1:0]            lits;
  logic [ROWS-1:0]            terms;

  assign lits = {fb_i, in_i};

  sop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  sop_cfg_store #(.ROWS(ROWS), .ROW_W(ROW_W), .AW(AW)) u_store (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .wr_en      (cfg_we),
    .wr_addr    (cfg_addr),
    .wr_data    (cfg_data),
    .rows_q     (row_q)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_term
    sop_term #(.LITS(LITS)) u_term (
      .lits (lits),
      .row  (row_q[r]),
      .term (terms[r])
    );
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign sum_o[k] = |terms[k*TPO +: SUM_SLOTS];
    assign oe_o[k]  = terms[k*TPO + SUM_SLOTS];
  end
endmodule

// File: rtl/sop_plane_chk.sv
module sop_plane_chk #(
  parameter int N_IN  = 12,
  parameter int N_FB  = 10,
  parameter int N_OUT = 10,
  localparam int LITS  = N_IN + N_FB,
  localparam int ROW_W = 2 * LITS,
  localparam int TPO   = 9,
  localparam int ROWS  = N_OUT * TPO,
  localparam int AW    = $clog2(ROWS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       core_rst_n,
  input logic                       cfg_we,
  input logic [AW-1:0]              cfg_addr,
  input logic [ROW_W-1:0]           cfg_data,
  input logic [ROWS-1:0][ROW_W-1:0] row_q,
  input logic [N_OUT-1:0]           sum_o,
  input logic [N_OUT-1:0]           oe_o
);
  // R2: rows stay erased while the plane is held in reset
  assert_erased_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> (row_q == '1 && sum_o == '0 && oe_o == '0));

  // R3: an accepted write lands in the addressed row
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && cfg_we && int'(cfg_addr) < ROWS)
      |=> row_q[$past(cfg_addr)] == $past(cfg_data));

  // R7: out-of-range writes leave every row alone
  assert_bad_addr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && int'(cfg_addr) >= ROWS) |=> $stable(row_q));

  // R9: no write, no change
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(row_q));

  // R8: nothing is written before the plane leaves reset
  assert_early_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |=> row_q == '1);

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    // R5: fully disconnected enable row reads 1
    assert_open_row_true_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (row_q[k*TPO+8] == '0) |-> oe_o[k]);
    // R6: erased enable row reads 0
    assert_erased_row_false_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (row_q[k*TPO+8] == '1) |-> !oe_o[k]);
  end
endmodule

bind sop_plane sop_plane_chk #(.N_IN(N_IN), .N_FB(N_FB), .N_OUT(N_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_data   (cfg_data),
  .row_q      (row_q),
  .sum_o      (sum_o),
  .oe_o       (oe_o)
);

// File: tb/sop_plane_test.sv
`timescale 1ns/1ps
module sop_plane_test;
  localparam int NI = 12, NF = 10, NO = 10, RW = 44, AWB = 7;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NI-1:0]  in_i;
  logic [NF-1:0]  fb_i;
  logic           cfg_we;
  logic [AWB-1:0] cfg_addr;
  logic [RW-1:0]  cfg_data;
  logic [NO-1:0]  sum_o, oe_o;

  int checks = 0, fails = 0;
  bit done = 0;
  // rows written so far (bench view of the programmed pattern)
  bit w29 = 0, w9 = 0, w12 = 0, w22 = 0, oe0 = 0;

  always #2.5 clk = ~clk;

  sop_plane uut (.clk(clk), .rst_n(rst_n), .in_i(in_i), .fb_i(fb_i),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .sum_o(sum_o), .oe_o(oe_o));

  task automatic chk(string req, logic [NO-1:0] act, logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] exp_sum();
    logic [NO-1:0] s = '0;
    if (w29) s[3] = 1'b1;
    s[1] = (w9 && in_i[0] && !in_i[5]) || (w12 && in_i[2]);
    if (w22) s[2] = fb_i[3];
    return s;
  endfunction

  function automatic logic [NO-1:0] exp_oe();
    logic [NO-1:0] e = '0;
    e[0] = oe0;
    return e;
  endfunction

  task automatic apply(logic [NI-1:0] a, logic [NF-1:0] b, string req);
    @(negedge clk);
    in_i = a; fb_i = b;
    #1;
    chk(req, sum_o, exp_sum());
    chk(req, oe_o, exp_oe());
  endtask

  task automatic wr(int addr, logic [RW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AWB'(addr); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_data = '0;
  endtask

  task automatic t_reset_R2();
    apply('0, '0, "R2");
    apply('1, '1, "R2");
    apply(12'hA5A, 10'h155, "R2");
  endtask

  task automatic t_release_R8();
    rst_n = 1'b0; in_i = '0; fb_i = '0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'd8; cfg_data = '0; rst_n = 1'b1;
    @(negedge clk); chk("R8 edge1", oe_o, '0);
    @(negedge clk); chk("R8 edge2", oe_o, '0);
    @(negedge clk); oe0 = 1; chk("R8 edge3", oe_o, exp_oe());
    cfg_we = 1'b0;
  endtask

  task automatic t_open_row_R5();
    wr(29, '0); w29 = 1;   // output 3 slot 2 fully open
    apply('0, '0, "R5 R4");
    apply('1, '1, "R5");
  endtask

  task automatic t_literals_R1();
    wr(9, 44'h402); w9 = 1;  // in0 true, in5 complement
    apply(12'h001, '0, "R1 in0=1 in5=0");
    apply(12'h021, '0, "R1 in0=1 in5=1");
    apply(12'h020, '0, "R1 in0=0 in5=1");
  endtask

  task automatic t_or_R4();
    wr(12, 44'h20); w12 = 1;  // output 1 slot 3: in2 true
    apply(12'h004, '0, "R4 second term");
    apply(12'h005, '0, "R4 both terms");
    apply(12'h020, '0, "R4 none");
  endtask

  task automatic t_feedback_R10();
    wr(22, 44'h8000_0000); w22 = 1;  // output 2 slot 4: fb3 true
    apply('0, 10'h008, "R10 fb3=1");
    apply('1, 10'h3F7, "R10 fb3=0");
  endtask

  task automatic t_erased_field_R6();
    wr(37, 44'hC000);  // output 4 slot 1: literal 7 both forms
    apply(12'h080, '0, "R6 in7=1");
    apply(12'h000, '1, "R6 in7=0");
  endtask

  task automatic t_bad_addr_R7();
    wr(90, '0);
    wr(127, '0);
    apply(12'h004, 10'h008, "R7");
  endtask

  task automatic t_hold_R9();
    @(negedge clk);
    cfg_addr = 7'd8; cfg_data = '1; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 hold", oe_o, exp_oe());
    apply(12'h001, '0, "R9 comb");
    apply(12'h000, 10'h008, "R9 comb");
  endtask

  task automatic t_rewrite_R3();
    wr(8, '1); oe0 = 0;  // erase output 0 enable row again
    apply('0, '0, "R3 rewrite");
    wr(8, '0); oe0 = 1;
    apply('0, '0, "R3 rewrite");
  endtask

  initial begin
    rst_n = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    in_i = '0; fb_i = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_R2();
    t_release_R8();
    t_open_row_R5();
    t_literals_R1();
    t_or_R4();
    t_feedback_R10();
    t_erased_field_R6();
    t_bad_addr_R7();
    t_hold_R9();
    t_rewrite_R3();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule